// File: doc/BRIEF.md
# Per-Lane Strobe Delay Window Calibrator

This block finds, for each byte lane of a memory data bus, the range of delay codes over which that lane works reliably. It steps a delay code from zero up to a fixed last code. At each step it asks an external test agent to run a probe with that code. The agent answers with one pass/fail bit per lane. The engine tracks the contiguous passing runs of every lane and keeps the widest one. When the sweep ends, it publishes the start, end, width and recommended code of each lane's chosen run.

A code unit is 1/256 of a clock period and the default stride is four units, so half a clock is 128 units. The engine has two modes. Strobe-gating mode biases the recommendation late: it takes the larger of the run midpoint and the run end minus half a clock. Data-delay mode takes the run midpoint. A data-delay sweep is refused until a gating sweep has completed since reset. A lane that never passes is flagged, and its numeric results are zeroed so that nobody uses them.

Top module: `dqs_window_cal`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `probe_valid_o` are low, `delay_code_o` is 0, and every per-lane output, including the bad flag, is 0.
- R2: An accepted sweep offers exactly one probe per code, in the order 0, STEP, 2·STEP, … up to SWEEP_LAST. While `probe_valid_o` waits for `probe_ready_i`, the code stays unchanged. The code advances only after `resp_valid_i` returns for the current probe.
- R3: In `resp_fail_i`, bit i belongs to lane i: 0 means the lane passed at the probed code and 1 means it failed.
- R4: A lane's window is its widest run of passing consecutive steps, where width is measured as end code minus start code. When two runs have the same width, the earlier run wins. `lane_start_o` and `lane_end_o` report the first and last code of that run.
- R5: In gating mode (`mode_i` = 0), the recommendation is max(⌊(start+end)/2⌋, end−128), where end−128 is taken as 0 when end < 128. The result is capped at the largest code.
- R6: In data-delay mode (`mode_i` = 1), the recommendation is ⌊(start+end)/2⌋.
- R7: `lane_width_o` of a valid lane equals end minus start.
- R8: A lane with no passing step in the sweep has its bit in `lane_bad_o` set, and its start, end, recommendation and width are all 0.
- R9: A data-delay start is ignored (no probe, no busy, no done) until a gating sweep has finished since reset.
- R10: `done_o` pulses high for exactly one cycle once the sweep ends, and `busy_o` is low during that cycle. The new results are visible in that same cycle. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a sweep (sampled when idle) |
| mode_i | input | 1 | 0 = strobe gating, 1 = data delay |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle end-of-sweep pulse |
| delay_code_o | output | CODE_W | Delay code under test |
| probe_valid_o | output | 1 | Probe request to the test agent |
| probe_ready_i | input | 1 | Agent accepts the probe |
| resp_valid_i | input | 1 | Agent result present |
| resp_fail_i | input | LANES | Per-lane fail bits, lane 0 in bit 0 |
| lane_start_o | output | LANES*CODE_W | Window start code per lane |
| lane_end_o | output | LANES*CODE_W | Window end code per lane |
| lane_rec_o | output | LANES*CODE_W | Recommended code per lane |
| lane_width_o | output | LANES*CODE_W | Window width per lane |
| lane_bad_o | output | LANES | Lane never passed |

## Verification
The hardest situation to reach is a lane with two passing runs of exactly equal width. The tie rule only shows up when the later run does not overwrite the earlier one. The bench builds such pass patterns in both modes, with runs that are single steps as well as long runs. It also places windows against code 0 and against the last code, so that the end-minus-half-clock term is clipped or wins. The test agent inserts random stalls on both the accept and the response, which exercises the code-hold rule.

// File: rtl/dqs_cal_pkg.sv
package dqs_cal_pkg;

    typedef enum logic {
        CAL_GATE = 1'b0,
        CAL_DATA = 1'b1
    } cal_mode_e;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_WAIT  = 2'd2,
        SEQ_FINAL = 2'd3
    } seq_state_e;

    // Recommended code from a window: midpoint, or late-biased for gating.
    function automatic int unsigned pick_rec(
        input int unsigned s,
        input int unsigned e,
        input cal_mode_e   mode,
        input int unsigned half,
        input int unsigned maxc
    );
        int unsigned mid;
        int unsigned late;
        int unsigned r;
        mid = (s + e) / 2;
        if (mode == CAL_DATA) begin
            r = mid;
        end else begin
            late = (e >= half) ? (e - half) : 0;
            r = (mid > late) ? mid : late;
        end
        if (r > maxc) r = maxc;
        return r;
    endfunction

endpackage

// File: rtl/dqs_cal_seq.sv
module dqs_cal_seq
    import dqs_cal_pkg::*;
#(
    parameter int CODE_W     = 10,
    parameter int STEP       = 4,
    parameter int SWEEP_LAST = 1020
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  cal_mode_e         mode_i,
    input  logic              probe_ready_i,
    input  logic              resp_valid_i,
    output logic              probe_valid_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [CODE_W-1:0] code_o,
    output logic              clr_o,
    output logic              step_o,
    output logic              commit_o,
    output cal_mode_e         mode_q_o
);
    localparam logic [CODE_W-1:0] LAST_C = CODE_W'(SWEEP_LAST);
    localparam logic [CODE_W-1:0] STEP_C = CODE_W'(STEP);

    seq_state_e state_q;
    logic       gate_seen_q;
    logic       accept;

    assign accept        = (state_q == SEQ_IDLE) && start_i &&
                           ((mode_i == CAL_GATE) || gate_seen_q);
    assign clr_o         = accept;
    assign step_o        = (state_q == SEQ_WAIT) && resp_valid_i;
    assign commit_o      = (state_q == SEQ_FINAL);
    assign probe_valid_o = (state_q == SEQ_ISSUE);
    assign busy_o        = (state_q != SEQ_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= SEQ_IDLE;
            gate_seen_q <= 1'b0;
            code_o      <= '0;
            done_o      <= 1'b0;
            mode_q_o    <= CAL_GATE;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                SEQ_IDLE: begin
                    if (accept) begin
                        code_o   <= '0;
                        mode_q_o <= mode_i;
                        state_q  <= SEQ_ISSUE;
                    end
                end
                SEQ_ISSUE: begin
                    if (probe_ready_i) state_q <= SEQ_WAIT;
                end
                SEQ_WAIT: begin
                    if (resp_valid_i) begin
                        if (code_o == LAST_C) begin
                            state_q <= SEQ_FINAL;
                        end else begin
                            code_o  <= code_o + STEP_C;
                            state_q <= SEQ_ISSUE;
                        end
                    end
                end
                SEQ_FINAL: begin
                    if (mode_q_o == CAL_GATE) gate_seen_q <= 1'b1;
                    done_o  <= 1'b1;
                    state_q <= SEQ_IDLE;
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assert_code_hold_R2: assert property (@(posedge clk) disable iff (rst)
        probe_valid_o && !probe_ready_i |=> probe_valid_o && $stable(code_o));

    assert_code_advance_R2: assert property (@(posedge clk) disable iff (rst)
        step_o && (code_o != LAST_C) |=> probe_valid_o && (code_o == $past(code_o) + STEP_C));

    assert_data_refused_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_IDLE) && start_i && (mode_i == CAL_DATA) && !gate_seen_q |=> !busy_o);

    assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

endmodule

// File: rtl/dqs_cal_lane.sv
module dqs_cal_lane
    import dqs_cal_pkg::*;
#(
    parameter int CODE_W   = 10,
    parameter int HALF_CLK = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_i,
    input  logic              step_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              pass_i,
    input  logic              commit_i,
    input  cal_mode_e         mode_i,
    output logic [CODE_W-1:0] start_o,
    output logic [CODE_W-1:0] end_o,
    output logic [CODE_W-1:0] rec_o,
    output logic [CODE_W-1:0] width_o,
    output logic              bad_o
);
    localparam int unsigned MAX_CODE = (1 << CODE_W) - 1;

    typedef struct packed {
        logic              have;
        logic [CODE_W-1:0] lo;
        logic [CODE_W-1:0] hi;
    } win_t;

    win_t              best_q;
    logic              in_run_q;
    logic [CODE_W-1:0] run_lo_q;
    logic [CODE_W-1:0] run_lo_eff;
    logic [CODE_W-1:0] run_len;
    logic [CODE_W-1:0] best_len;
    logic              take;

    assign run_lo_eff = in_run_q ? run_lo_q : code_i;
    assign run_len    = code_i - run_lo_eff;
    assign best_len   = best_q.hi - best_q.lo;
    assign take       = pass_i && (!best_q.have || (run_len > best_len));

    always_ff @(posedge clk) begin
        if (rst) begin
            best_q   <= '0;
            in_run_q <= 1'b0;
            run_lo_q <= '0;
        end else if (clr_i) begin
            best_q   <= '0;
            in_run_q <= 1'b0;
            run_lo_q <= '0;
        end else if (step_i) begin
            if (pass_i) begin
                in_run_q <= 1'b1;
                run_lo_q <= run_lo_eff;
                if (take) best_q <= '{have: 1'b1, lo: run_lo_eff, hi: code_i};
            end else begin
                in_run_q <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start_o <= '0;
            end_o   <= '0;
            rec_o   <= '0;
            width_o <= '0;
            bad_o   <= 1'b0;
        end else if (commit_i) begin
            if (best_q.have) begin
                start_o <= best_q.lo;
                end_o   <= best_q.hi;
                width_o <= best_len;
                rec_o   <= CODE_W'(pick_rec(32'(best_q.lo), 32'(best_q.hi),
                                            mode_i, HALF_CLK, MAX_CODE));
                bad_o   <= 1'b0;
            end else begin
                start_o <= '0;
                end_o   <= '0;
                width_o <= '0;
                rec_o   <= '0;
                bad_o   <= 1'b1;
            end
        end
    end

    assert_rec_inside_R5: assert property (@(posedge clk) disable iff (rst)
        commit_i ##1 !bad_o |-> (rec_o >= start_o) && (rec_o <= end_o));

    assert_bad_zeroed_R8: assert property (@(posedge clk) disable iff (rst)
        commit_i ##1 bad_o |-> (start_o == '0) && (end_o == '0) && (rec_o == '0) && (width_o == '0));

    assert_width_match_R7: assert property (@(posedge clk) disable iff (rst)
        commit_i |=> bad_o || (width_o == end_o - start_o));

endmodule

// File: rtl/dqs_window_cal.sv
module dqs_window_cal
    import dqs_cal_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int CODE_W     = 10,
    parameter int STEP       = 4,
    parameter int SWEEP_LAST = 1020,
    parameter int HALF_CLK   = 128
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start_i,
    input  logic                     mode_i,
    output logic                     busy_o,
    output logic                     done_o,
    output logic [CODE_W-1:0]        delay_code_o,
    output logic                     probe_valid_o,
    input  logic                     probe_ready_i,
    input  logic                     resp_valid_i,
    input  logic [LANES-1:0]         resp_fail_i,
    output logic [LANES*CODE_W-1:0]  lane_start_o,
    output logic [LANES*CODE_W-1:0]  lane_end_o,
    output logic [LANES*CODE_W-1:0]  lane_rec_o,
    output logic [LANES*CODE_W-1:0]  lane_width_o,
    output logic [LANES-1:0]         lane_bad_o
);
    logic      clr, step, commit;
    cal_mode_e mode_q;
    cal_mode_e mode_in;

    assign mode_in = cal_mode_e'(mode_i);

    dqs_cal_seq #(
        .CODE_W     (CODE_W),
        .STEP       (STEP),
        .SWEEP_LAST (SWEEP_LAST)
    ) u_seq (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start_i),
        .mode_i        (mode_in),
        .probe_ready_i (probe_ready_i),
        .resp_valid_i  (resp_valid_i),
        .probe_valid_o (probe_valid_o),
        .busy_o        (busy_o),
        .done_o        (done_o),
        .code_o        (delay_code_o),
        .clr_o         (clr),
        .step_o        (step),
        .commit_o      (commit),
        .mode_q_o      (mode_q)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dqs_cal_lane #(
            .CODE_W   (CODE_W),
            .HALF_CLK (HALF_CLK)
        ) u_lane (
            .clk      (clk),
            .rst      (rst),
            .clr_i    (clr),
            .step_i   (step),
            .code_i   (delay_code_o),
            .pass_i   (!resp_fail_i[g]),
            .commit_i (commit),
            .mode_i   (mode_q),
            .start_o  (lane_start_o[g*CODE_W +: CODE_W]),
            .end_o    (lane_end_o[g*CODE_W +: CODE_W]),
            .rec_o    (lane_rec_o[g*CODE_W +: CODE_W]),
            .width_o  (lane_width_o[g*CODE_W +: CODE_W]),
            .bad_o    (lane_bad_o[g])
        );
    end

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o && !probe_valid_o);

    assert_probe_only_busy_R2: assert property (@(posedge clk) disable iff (rst)
        probe_valid_o |-> busy_o);

endmodule

// File: tb/tb_dqs_window_cal.sv
module tb_dqs_window_cal;
    localparam int LANES = 4;
    localparam int CW    = 10;
    localparam int STEP  = 4;
    localparam int LAST  = 1020;
    localparam int HALF  = 128;

    typedef struct packed {
        logic [CW-1:0] s;
        logic [CW-1:0] e;
        logic [CW-1:0] r;
        logic [CW-1:0] w;
        logic          bad;
    } exp_t;

    logic clk = 1'b0;
    logic rst, start, mode, busy, done, pv, pr, rv;
    logic [CW-1:0] code;
    logic [LANES-1:0] rfail;
    logic [LANES*CW-1:0] l_s, l_e, l_r, l_w;
    logic [LANES-1:0] l_bad;

    int checks = 0;
    int fails  = 0;
    int exp_code = 0;
    bit finished = 0;
    exp_t q[$];
    int lo1[LANES], hi1[LANES], lo2[LANES], hi2[LANES];

    always #4 clk = ~clk;

    dqs_window_cal dut (
        .clk(clk), .rst(rst), .start_i(start), .mode_i(mode),
        .busy_o(busy), .done_o(done), .delay_code_o(code),
        .probe_valid_o(pv), .probe_ready_i(pr), .resp_valid_i(rv),
        .resp_fail_i(rfail), .lane_start_o(l_s), .lane_end_o(l_e),
        .lane_rec_o(l_r), .lane_width_o(l_w), .lane_bad_o(l_bad)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit lane_pass(input int l, input int c);
        return ((c >= lo1[l]) && (c <= hi1[l])) || ((c >= lo2[l]) && (c <= hi2[l]));
    endfunction

    task automatic set_lane(input int l, input int a1, input int b1, input int a2, input int b2);
        lo1[l] = a1; hi1[l] = b1; lo2[l] = a2; hi2[l] = b2;
    endtask

    // Driver: build expected results from the requirements, then start.
    task automatic run_sweep(input bit m);
        for (int l = 0; l < LANES; l++) begin
            int bs = 0, be = 0, rs = 0, rec = 0, late = 0;
            bit have = 0, inrun = 0;
            exp_t x;
            for (int c = 0; c <= LAST; c += STEP) begin
                if (lane_pass(l, c)) begin
                    if (!inrun) rs = c;
                    inrun = 1;
                    if (!have || (c - rs) > (be - bs)) begin
                        bs = rs; be = c; have = 1;
                    end
                end else inrun = 0;
            end
            if (have) begin
                rec = (bs + be) / 2;
                if (!m) begin
                    late = (be >= HALF) ? be - HALF : 0;
                    if (late > rec) rec = late;
                end
                if (rec > 1023) rec = 1023;
                x = '{s: CW'(bs), e: CW'(be), r: CW'(rec), w: CW'(be - bs), bad: 1'b0};
            end else begin
                x = '{s: '0, e: '0, r: '0, w: '0, bad: 1'b1};
            end
            q.push_back(x);
        end
        exp_code = 0;
        @(negedge clk);
        mode = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", busy, 1);
        do @(negedge clk); while (!done);
        @(negedge clk);
        chk(done == 1'b0, "R10 done single cycle", done, 0);
    endtask

    // Test agent: random stalls, checks the code order, answers per lane.
    initial begin
        pr = 1'b0; rv = 1'b0; rfail = '0;
        forever begin
            @(negedge clk);
            if (pv) begin
                int cap;
                repeat ($urandom_range(0, 2)) begin
                    @(negedge clk);
                    chk(pv == 1'b1 && int'(code) == exp_code, "R2 code held while stalled", int'(code), exp_code);
                end
                cap = int'(code);
                chk(cap == exp_code, "R2 code order", cap, exp_code);
                exp_code += STEP;
                pr = 1'b1;
                @(negedge clk);
                pr = 1'b0;
                repeat ($urandom_range(0, 2)) @(negedge clk);
                for (int l = 0; l < LANES; l++) rfail[l] = !lane_pass(l, cap);
                rv = 1'b1;
                @(negedge clk);
                rv = 1'b0;
            end
        end
    end

    // Monitor: pop expected lanes on each done and compare.
    initial begin
        forever begin
            @(negedge clk);
            if (done) begin
                chk(busy == 1'b0, "R10 idle at done", busy, 0);
                chk(exp_code == LAST + STEP, "R2 probe count", exp_code, LAST + STEP);
                for (int l = 0; l < LANES; l++) begin
                    exp_t x;
                    if (q.size() == 0) begin
                        chk(1'b0, "R10 unexpected done", 1, 0);
                    end else begin
                        x = q.pop_front();
                        chk(l_s[l*CW +: CW] == x.s, "R4 start", int'(l_s[l*CW +: CW]), int'(x.s));
                        chk(l_e[l*CW +: CW] == x.e, "R4 end", int'(l_e[l*CW +: CW]), int'(x.e));
                        chk(l_r[l*CW +: CW] == x.r, "R5/R6 rec", int'(l_r[l*CW +: CW]), int'(x.r));
                        chk(l_w[l*CW +: CW] == x.w, "R7 width", int'(l_w[l*CW +: CW]), int'(x.w));
                        chk(l_bad[l] == x.bad, "R8 bad flag (R3 lane order)", int'(l_bad[l]), int'(x.bad));
                    end
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            chk(1'b0, "watchdog", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; start = 1'b0; mode = 1'b0;
        for (int l = 0; l < LANES; l++) set_lane(l, 1, 0, 1, 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 0 && done == 0 && pv == 0, "R1 control idle", int'({busy, done, pv}), 0);
        chk(code == 0, "R1 code zero", int'(code), 0);
        chk(l_s == 0 && l_e == 0 && l_r == 0 && l_w == 0 && l_bad == 0, "R1 results zero", int'(l_bad), 0);

        // R9: data sweep refused before any gating sweep.
        mode = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) begin
            chk(busy == 0 && pv == 0 && done == 0, "R9 data start ignored", int'({busy, pv, done}), 0);
            @(negedge clk);
        end

        // Gating sweep: late term wins on lanes 0/1, two runs on lane 2, dead lane 3.
        set_lane(0, 100, 400, 1, 0);
        set_lane(1, 0, 600, 1, 0);
        set_lane(2, 40, 80, 500, 600);
        set_lane(3, 1, 0, 1, 0);
        fork
            run_sweep(1'b0);
            begin
                // R10: a start while busy must not disturb the sweep.
                repeat (40) @(negedge clk);
                mode = 1'b1; start = 1'b1;
                @(negedge clk);
                start = 1'b0; mode = 1'b0;
            end
        join

        // Data sweep: equal-width tie, window at the last code, full range, single-step tie.
        set_lane(0, 8, 120, 300, 412);
        set_lane(1, 1020, 1020, 1, 0);
        set_lane(2, 0, 1020, 1, 0);
        set_lane(3, 64, 64, 200, 200);
        run_sweep(1'b1);

        // Gating again: late term clipped at zero, single step, full range, equal-width tie.
        set_lane(0, 0, 100, 1, 0);
        set_lane(1, 12, 12, 1, 0);
        set_lane(2, 0, 1020, 1, 0);
        set_lane(3, 600, 700, 800, 900);
        run_sweep(1'b0);

        repeat (4) @(negedge clk);
        chk(q.size() == 0, "R10 all sweeps reported", q.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule